// File: doc/BRIEF.md
# Double-Buffered Serial Converter Code Port

This block is the digital front end of a 16-bit converter. An external controller selects the port with an active-low select and clocks a code in serially, most significant bit first. The code goes into a staging register. A separate load strobe then copies the staged code into the holding register, which drives the converter core. Because the two registers are separate, a new code can be shifted in while the output still shows the old one. Several outputs can then be updated together by one shared load strobe.

The serial clock, select, data, load strobe, clear and preset-select pins are all sampled in one system clock domain. Each pin passes through a synchronizer chain, and edges are found by comparing successive synchronized samples. An active-low clear, which needs no serial clock or load edge, forces both registers to a preset. The preset is mid-scale (0x8000) when the preset-select pin is high and zero when it is low. The serial output shows the bit that is about to leave the top of the staging register, so several ports can be chained. Its drive-enable is active only while the port is selected.

Top module: `dac_serial_port`

## Requirements
- R1: While `cs_n` is low, each rising edge of `sclk` shifts one `sdi` bit into the bottom of the 16-bit staging register, MSB first. After 16 rising edges and one load, `dac_code` equals the word that was sent.
- R2: While `cs_n` is high, `sclk` and `sdi` activity leaves the staging register unchanged.
- R3: `sdo_drive` is 0 while `cs_n` is high and 1 while `cs_n` is low, each within SYNC_STAGES+1 system clocks of the change.
- R4: A rising edge on `load` copies the staging register into `dac_code`. Shifting without a load edge never changes `dac_code`.
- R5: While `clear_n` is low and `preset_mid` is high, both registers are forced to 0x8000.
- R6: While `clear_n` is low and `preset_mid` is low, both registers are forced to 0x0000.
- R7: The clear takes effect within SYNC_STAGES+1 system clocks and needs no `sclk` or `load` edge. While the clear is held, shifts and loads have no effect.
- R8: When `cs_n` falls, and on each falling `sclk` edge while `cs_n` is low, `sdo_data` is updated to the current staging-register MSB. The 16 bits seen just before successive rising edges therefore reproduce the previous staging content, MSB first.
- R9: A synchronous active-high `rst` sets `dac_code` to 0 and `sdo_drive` to 0.
- R10: Loading is edge-triggered. Holding `load` high while a new word is shifted in does not update `dac_code` until `load` falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock pin, idles high |
| cs_n | input | 1 | Active-low port select |
| sdi | input | 1 | Serial data in |
| load | input | 1 | Load strobe, rising edge active |
| clear_n | input | 1 | Active-low clear to preset |
| preset_mid | input | 1 | Preset choice: 1 = mid-scale, 0 = zero |
| sdo_data | output | 1 | Serial data out value |
| sdo_drive | output | 1 | Output enable for the serial data out buffer |
| dac_code | output | 16 | Holding-register code to the converter core |

## Verification
The assertions assume that every pin holds each level for at least SYNC_STAGES+1 system clocks. They also assume that `sdi` has settled before the matching `sclk` rise is seen, and that `cs_n` rises only while `sclk` is high. With those assumptions, each synchronized edge stands for exactly one intended event. The stimulus holds every serial clock phase, select change and strobe for four system clocks, which is longer than the three-cycle synchronizer latency. It also always deselects with the serial clock high. Within that timing, the bench sweeps walking-one and mixed codes, chains the previous content out, and covers both clear presets and a held load strobe.

// File: rtl/dac_port_pkg.sv
package dac_port_pkg;
  typedef enum logic {
    PRESET_ZERO = 1'b0,
    PRESET_MID  = 1'b1
  } preset_e;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int N = 1,
  parameter int STAGES = 2,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] level
);
  logic [N-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= INIT;
    else     stage_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= INIT;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign level = stage_q[STAGES-1];
endmodule

// File: rtl/edge_tap.sv
module edge_tap #(
  parameter int N = 1,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= INIT;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             cs_level,
  input  logic             cs_fall,
  input  logic             sdi_level,
  input  logic             clear_active,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] stage_reg,
  output logic             sdo_data,
  output logic             sdo_drive
);
  logic shift_en;
  logic present_en;

  assign shift_en   = sclk_rise & ~cs_level;
  assign present_en = cs_fall | (sclk_fall & ~cs_level);

  always_ff @(posedge clk) begin
    if (rst)               stage_reg <= '0;
    else if (clear_active) stage_reg <= preset;
    else if (shift_en)     stage_reg <= {stage_reg[WIDTH-2:0], sdi_level};
  end

  always_ff @(posedge clk) begin
    if (rst)             sdo_data <= 1'b0;
    else if (present_en) sdo_data <= stage_reg[WIDTH-1];
  end

  always_ff @(posedge clk) begin
    if (rst) sdo_drive <= 1'b0;
    else     sdo_drive <= ~cs_level;
  end

  // R2: deselected port keeps its staging content
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (cs_level && !clear_active) |=> $stable(stage_reg));
  // R1: a shift lands the sampled data bit at the bottom
  a_r1_shift_in: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !cs_level && !clear_active) |=> stage_reg[0] == $past(sdi_level));
  // R3: drive follows select
  a_r3_drive_off: assert property (@(posedge clk) disable iff (rst)
    cs_level |=> !sdo_drive);
  // R8: serial output moves only on select fall or serial clock fall
  a_r8_sdo_hold: assert property (@(posedge clk) disable iff (rst)
    (!cs_fall && !sclk_fall) |=> $stable(sdo_data));
endmodule

// File: rtl/dac_holding.sv
module dac_holding #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_rise,
  input  logic             clear_active,
  input  logic [WIDTH-1:0] preset,
  input  logic [WIDTH-1:0] stage_reg,
  output logic [WIDTH-1:0] dac_q
);
  always_ff @(posedge clk) begin
    if (rst)               dac_q <= '0;
    else if (clear_active) dac_q <= preset;
    else if (load_rise)    dac_q <= stage_reg;
  end

  // R4: holding register only moves on a load edge or a clear
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_rise && !clear_active) |=> $stable(dac_q));
  // R4: load edge copies the staged code
  a_r4_copy: assert property (@(posedge clk) disable iff (rst)
    (load_rise && !clear_active) |=> dac_q == $past(stage_reg));
endmodule

// File: rtl/dac_serial_port.sv
module dac_serial_port #(
  parameter int WIDTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             sdi,
  input  logic             load,
  input  logic             clear_n,
  input  logic             preset_mid,
  output logic             sdo_data,
  output logic             sdo_drive,
  output logic [WIDTH-1:0] dac_code
);
  import dac_port_pkg::*;

  localparam logic [WIDTH-1:0] MID_CODE = {1'b1, {(WIDTH-1){1'b0}}};
  // pin vector order: clear_n, preset_mid, load, sdi, cs_n, sclk
  localparam int NPIN = 6;
  localparam logic [NPIN-1:0] PIN_IDLE = 6'b100011;
  localparam logic [2:0] EDGE_IDLE = 3'b011;

  logic [NPIN-1:0] pin_s;
  logic [2:0]      edge_rise, edge_fall;
  logic            sclk_s, cs_s, sdi_s, load_s, sel_s, clear_s;
  preset_e         kind;
  logic [WIDTH-1:0] preset;
  logic            clear_active;
  logic [WIDTH-1:0] stage_reg;

  sync_chain #(.N(NPIN), .STAGES(SYNC_STAGES), .INIT(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst),
    .din({clear_n, preset_mid, load, sdi, cs_n, sclk}),
    .level(pin_s)
  );

  assign {clear_s, sel_s, load_s, sdi_s, cs_s, sclk_s} = pin_s;

  edge_tap #(.N(3), .INIT(EDGE_IDLE)) u_edge (
    .clk(clk), .rst(rst),
    .level({load_s, cs_s, sclk_s}),
    .rise(edge_rise), .fall(edge_fall)
  );

  assign kind         = sel_s ? PRESET_MID : PRESET_ZERO;
  assign preset       = (kind == PRESET_MID) ? MID_CODE : '0;
  assign clear_active = ~clear_s;

  serial_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst(rst),
    .sclk_rise(edge_rise[0]), .sclk_fall(edge_fall[0]),
    .cs_level(cs_s), .cs_fall(edge_fall[1]),
    .sdi_level(sdi_s), .clear_active(clear_active),
    .preset(preset), .stage_reg(stage_reg),
    .sdo_data(sdo_data), .sdo_drive(sdo_drive)
  );

  dac_holding #(.WIDTH(WIDTH)) u_hold (
    .clk(clk), .rst(rst),
    .load_rise(edge_rise[2]), .clear_active(clear_active),
    .preset(preset), .stage_reg(stage_reg),
    .dac_q(dac_code)
  );

  // R5: clear with mid-scale select
  a_r5_mid_preset: assert property (@(posedge clk) disable iff (rst)
    (!clear_s && sel_s) |=> (dac_code == MID_CODE && stage_reg == MID_CODE));
  // R6: clear with zero select
  a_r6_zero_preset: assert property (@(posedge clk) disable iff (rst)
    (!clear_s && !sel_s) |=> (dac_code == '0 && stage_reg == '0));
  // R9: system reset
  a_r9_reset: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && !sdo_drive));
  // R10: a held strobe loads nothing
  a_r10_held_load: assert property (@(posedge clk) disable iff (rst)
    (load_s && $past(load_s) && clear_s) |=> $stable(dac_code));
endmodule

// File: tb/sim_dac_serial_port.sv
module sim_dac_serial_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0, load = 1'b0;
  logic clear_n = 1'b1, preset_mid = 1'b0;
  logic sdo_data, sdo_drive;
  logic [15:0] dac_code;
  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] stage_model, dac_model, seen, w;

  always #2.5 clk = ~clk;

  dac_serial_port #(.WIDTH(16), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .load(load), .clear_n(clear_n), .preset_mid(preset_mid),
    .sdo_data(sdo_data), .sdo_drive(sdo_drive), .dac_code(dac_code)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic shift_word(input logic [15:0] word, output logic [15:0] got);
    cs_n = 1'b0;
    half();
    chk("R3 drive on", {15'd0, sdo_drive}, 16'd1);
    for (int i = 15; i >= 0; i--) begin
      sclk = 1'b0;
      sdi = word[i];
      half();
      got[i] = sdo_data;
      sclk = 1'b1;
      half();
    end
    cs_n = 1'b1;
    half();
    chk("R3 drive off", {15'd0, sdo_drive}, 16'd0);
  endtask

  task automatic pulse_load();
    load = 1'b1;
    half();
    load = 1'b0;
    half();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    half();
    chk("R9 reset dac", dac_code, 16'h0000);
    chk("R9 reset drive", {15'd0, sdo_drive}, 16'd0);
    stage_model = 16'h0000;
    dac_model = 16'h0000;

    // R1 R4 R8: walking ones and mixed codes
    for (int k = 0; k < 24; k++) begin
      w = (k < 16) ? (16'h0001 << k) : (16'(k * 40503) ^ 16'h5A5A);
      shift_word(w, seen);
      chk("R8 chained out", seen, stage_model);
      chk("R4 no change before load", dac_code, dac_model);
      pulse_load();
      chk("R1 loaded word", dac_code, w);
      stage_model = w;
      dac_model = w;
    end

    // R2: serial activity while deselected
    for (int i = 0; i < 6; i++) begin
      sdi = ~sdi;
      sclk = 1'b0;
      half();
      sclk = 1'b1;
      half();
    end
    pulse_load();
    chk("R2 ignored while deselected", dac_code, stage_model);

    // R10: load held high during a shift
    load = 1'b1;
    half();
    shift_word(16'h1234, seen);
    chk("R10 held load no update", dac_code, dac_model);
    load = 1'b0;
    half();
    load = 1'b1;
    half();
    chk("R10 fresh edge loads", dac_code, 16'h1234);
    load = 1'b0;
    half();
    stage_model = 16'h1234;

    // R5 R7: clear to mid-scale
    preset_mid = 1'b1;
    clear_n = 1'b0;
    half();
    chk("R7 R5 clear mid without edges", dac_code, 16'h8000);
    shift_word(16'h0F0F, seen);
    pulse_load();
    chk("R7 shift and load ignored in clear", dac_code, 16'h8000);
    clear_n = 1'b1;
    half();
    pulse_load();
    chk("R5 staging also mid", dac_code, 16'h8000);
    shift_word(16'hAAAA, seen);
    chk("R8 R5 mid chained out", seen, 16'h8000);

    // R6: clear to zero
    preset_mid = 1'b0;
    clear_n = 1'b0;
    half();
    chk("R6 clear zero", dac_code, 16'h0000);
    clear_n = 1'b1;
    half();
    pulse_load();
    chk("R6 staging also zero", dac_code, 16'h0000);
    shift_word(16'hC3C3, seen);
    chk("R8 R6 zero chained out", seen, 16'h0000);
    pulse_load();
    chk("R1 after clear", dac_code, 16'hC3C3);

    // R9: reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 reset mid run", dac_code, 16'h0000);
    rst = 1'b0;
    half();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule